// File: doc/BRIEF.md
# Doorbell Write Pre-Translator

This block sits on the path to an interrupt translation doorbell register. Bus masters issue 32-bit writes on a simple valid/ready bus. A write that falls inside a configurable window is forwarded as a doorbell event. The event carries a device identifier that the block takes from the word index of the write within that window. A write aimed straight at the doorbell address is forwarded as an event from device 0. The identity of the source is therefore carried in the address, not in sideband signals, so one master can pose as any device in the window.

The window base, the number of device-ID bits and the doorbell address are all configuration inputs. Each accepted write gets a one-cycle response code. Only a clean, whole-word, aligned write makes an event. The event leaves on a valid/ready port and is held there until it is taken. While it waits, the write bus is stalled.

The control is a two-state machine:
- `ST_IDLE`: no event is pending, and writes are accepted.
- `ST_HOLD`: an event is presented.

The transitions are:
- `IDLE->HOLD`: a good write is accepted.
- `HOLD->IDLE`: the event is taken and no new good write arrives in the same cycle.
- `HOLD->HOLD`: either the event is stalled, or it is taken in the same cycle that a new good write is accepted.
- `IDLE->IDLE`: there is no write, or the write is rejected.

Top module: `dbx_pretranslate`

## Requirements
- R1: After reset, `wr_ready` is 1, `ev_valid` is 0 and `rsp_valid` is 0.
- R2: A write with `wr_strb` = 4'b1111 to address base+N passes when N is a multiple of 4 and N < (4 << k), where k is the effective ID-bit count. It produces an event with `ev_devid` = N/4, `ev_data` = `wr_data`, and response code 2'b00 (OK).
- R3: A write with `wr_strb` = 4'b1111 to `cfg_db_addr` produces an event with `ev_devid` = 0 and response code 2'b00.
- R4: A write that hits neither the window nor the doorbell address gets response code 2'b10 (DECODE) and produces no event.
- R5: A write to the window or to the doorbell is dropped with response code 2'b01 (FORMAT), and produces no event, if `wr_strb` is not 4'b1111 or if its window offset is not a multiple of 4.
- R6: If `cfg_id_bits` is above the parameter ID_W, the effective ID-bit count is ID_W, so the window spans 4 << ID_W bytes.
- R7: When the doorbell address lies inside the window, a write to it is reported as device 0, not by its window offset.
- R8: While `ev_valid` is 1 and `ev_ready` is 0, `wr_ready` is 0 and `ev_devid`/`ev_data` hold their values.
- R9: Every accepted write gives `rsp_valid` = 1 for exactly the one cycle after acceptance. No response appears without a write.
- R10: When `ev_ready` is 1 with an event pending, a write on the bus is accepted in that same cycle. Its event (if any) is valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_win_base | input | ADDR_W | Window base address |
| cfg_id_bits | input | IDB_W | Requested number of device-ID bits |
| cfg_db_addr | input | ADDR_W | Direct doorbell address |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted |
| wr_addr | input | ADDR_W | Write byte address |
| wr_strb | input | 4 | Byte enables |
| wr_data | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_code | output | 2 | 00 OK, 01 FORMAT, 10 DECODE |
| ev_valid | output | 1 | Doorbell event valid |
| ev_ready | input | 1 | Doorbell event taken |
| ev_devid | output | ID_W | Event device ID |
| ev_data | output | 32 | Event payload |

## Verification
Two functions can fall in the same cycle: the pending event can be taken and a new write accepted on that one edge. The bench provokes this by stalling an event, holding a second write on the bus for several cycles, and then raising `ev_ready` while that write is still offered. The result is judged in the next cycle, which must show the new device ID and data in place of the old event, together with a response for the new write. The same is repeated with a rejected second write, after which no event may remain.

// File: rtl/dbx_pkg.sv
package dbx_pkg;
    typedef enum logic [1:0] {
        RSP_OK     = 2'b00,
        RSP_FORMAT = 2'b01,
        RSP_DECODE = 2'b10
    } rsp_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } st_e;
endpackage

// File: rtl/dbx_decode.sv
module dbx_decode
    import dbx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ID_W   = 4,
    parameter int IDB_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        strb,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [IDB_W-1:0]  id_bits,
    input  logic [ADDR_W-1:0] db_addr,
    output rsp_e              code,
    output logic [ID_W-1:0]   devid
);
    localparam logic [IDB_W-1:0] ID_CAP = IDB_W'(ID_W);

    logic [IDB_W-1:0]  eff_bits;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W:0]   win_bytes;
    logic [ID_W-1:0]   id_mask;
    logic              in_win;
    logic              db_hit;
    logic              full_word;

    // Clamp the requested ID width, then size the window from it
    always_comb begin
        eff_bits  = (id_bits > ID_CAP) ? ID_CAP : id_bits;
        off       = addr - win_base;
        win_bytes = (ADDR_W+1)'(4) << eff_bits;
        id_mask   = ~({ID_W{1'b1}} << eff_bits);
        in_win    = (addr >= win_base) && ({1'b0, off} < win_bytes);
        db_hit    = (addr == db_addr);
        full_word = (strb == 4'b1111);
    end

    // Doorbell match has priority over the window
    always_comb begin
        code  = RSP_DECODE;
        devid = '0;
        if (db_hit) begin
            code = full_word ? RSP_OK : RSP_FORMAT;
        end else if (in_win) begin
            if (full_word && (off[1:0] == 2'b00)) begin
                code  = RSP_OK;
                devid = off[ID_W+1:2] & id_mask;
            end else begin
                code = RSP_FORMAT;
            end
        end
    end
endmodule

// File: rtl/dbx_emit.sv
module dbx_emit
    import dbx_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    output logic            wr_ready,
    input  rsp_e            code,
    input  logic [ID_W-1:0] devid,
    input  logic [31:0]     data,
    output logic            ev_valid,
    input  logic            ev_ready,
    output logic [ID_W-1:0] ev_devid,
    output logic [31:0]     ev_data,
    output logic            rsp_valid,
    output rsp_e            rsp_code
);
    st_e  state, state_nx;
    logic fire;
    logic take;

    assign fire = wr_valid && wr_ready;
    assign take = fire && (code == RSP_OK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (take) state_nx = ST_HOLD;
            ST_HOLD: if (ev_ready) state_nx = take ? ST_HOLD : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        wr_ready = 1'b1;
        ev_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                wr_ready = 1'b1;
                ev_valid = 1'b0;
            end
            ST_HOLD: begin
                wr_ready = ev_ready;
                ev_valid = 1'b1;
            end
            default: begin
                wr_ready = 1'b0;
                ev_valid = 1'b0;
            end
        endcase
    end

    // Event payload and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_devid  <= '0;
            ev_data   <= '0;
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_OK;
        end else begin
            if (take) begin
                ev_devid <= devid;
                ev_data  <= data;
            end
            rsp_valid <= fire;
            if (fire) rsp_code <= code;
        end
    end

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_devid) && $stable(ev_data)));

    p_stall_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |-> !wr_ready);

    p_resp_after_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> rsp_valid);

    p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && wr_ready) |=> !rsp_valid);

    p_ok_has_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_OK) |-> ev_valid);

    p_reject_no_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != RSP_OK) |-> !ev_valid);

    p_drain_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |-> wr_ready);
endmodule

// File: rtl/dbx_pretranslate.sv
module dbx_pretranslate
    import dbx_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ID_W   = 4,
    parameter int IDB_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_win_base,
    input  logic [IDB_W-1:0]  cfg_id_bits,
    input  logic [ADDR_W-1:0] cfg_db_addr,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_strb,
    input  logic [31:0]       wr_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [ID_W-1:0]   ev_devid,
    output logic [31:0]       ev_data
);
    rsp_e            dec_code;
    rsp_e            rsp_code_e;
    logic [ID_W-1:0] dec_devid;

    dbx_decode #(
        .ADDR_W (ADDR_W),
        .ID_W   (ID_W),
        .IDB_W  (IDB_W)
    ) u_decode (
        .addr     (wr_addr),
        .strb     (wr_strb),
        .win_base (cfg_win_base),
        .id_bits  (cfg_id_bits),
        .db_addr  (cfg_db_addr),
        .code     (dec_code),
        .devid    (dec_devid)
    );

    dbx_emit #(
        .ID_W (ID_W)
    ) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .code      (dec_code),
        .devid     (dec_devid),
        .data      (wr_data),
        .ev_valid  (ev_valid),
        .ev_ready  (ev_ready),
        .ev_devid  (ev_devid),
        .ev_data   (ev_data),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code_e)
    );

    assign rsp_code = rsp_code_e;
endmodule

// File: tb/dbx_pretranslate_tb.sv
module dbx_pretranslate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_win_base = 16'h1000;
    logic [2:0]  cfg_id_bits = 3'd2;
    logic [15:0] cfg_db_addr = 16'h0040;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [15:0] wr_addr = '0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wr_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic        ev_valid;
    logic        ev_ready = 1'b0;
    logic [3:0]  ev_devid;
    logic [31:0] ev_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    dbx_pretranslate u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_win_base(cfg_win_base), .cfg_id_bits(cfg_id_bits), .cfg_db_addr(cfg_db_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_strb(wr_strb), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_devid(ev_devid), .ev_data(ev_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected classification from the requirements: 0 OK, 1 FORMAT, 2 DECODE
    task automatic model(input logic [15:0] a, input logic [3:0] s,
                         output int c, output int d);
        int eff, wb, off;
        eff = (cfg_id_bits > 3'd4) ? 4 : int'(cfg_id_bits);
        wb  = 4 << eff;
        off = int'(a) - int'(cfg_win_base);
        d   = 0;
        if (a == cfg_db_addr)            c = (s == 4'hF) ? 0 : 1;
        else if (off >= 0 && off < wb) begin
            if (s == 4'hF && (off % 4) == 0) begin c = 0; d = off / 4; end
            else c = 1;
        end else c = 2;
    endtask

    task automatic xfer(input logic [15:0] a, input logic [3:0] s,
                        input logic [31:0] dat, input string ctx);
        int c, d;
        string tag;
        model(a, s, c, d);
        if (c == 0) tag = (a == cfg_db_addr) ? "R3 doorbell" : "R2 window";
        else if (c == 1) tag = "R5 format";
        else tag = "R4 decode";
        tag = {tag, " ", ctx};
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_strb = s; wr_data = dat;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        #1 wr_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b1, {"R9 rsp ", tag}, rsp_valid, 1);
        chk(rsp_code == 2'(c), tag, rsp_code, c);
        chk(ev_valid == (c == 0), {"event ", tag}, ev_valid, (c == 0));
        if (c == 0) begin
            chk(ev_devid == 4'(d), {"devid ", tag}, ev_devid, d);
            chk(ev_data == dat, {"data ", tag}, ev_data, dat);
        end
        ev_ready = 1'b1;
        @(negedge clk);
        ev_ready = 1'b0;
        chk(!ev_valid, {"drained ", tag}, ev_valid, 0);
        chk(!rsp_valid, {"R9 one-cycle ", tag}, rsp_valid, 0);
    endtask

    // Stall an event, hold a second write, then release: R8 and R10
    task automatic overlap(input logic [15:0] a2, input int exp_c, input int exp_d);
        xfer_hold(16'h1008, 32'h1111_0002);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a2; wr_strb = 4'hF; wr_data = 32'h2222_0000 | 32'(a2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!wr_ready, "R8 stall", wr_ready, 0);
            chk(ev_valid && ev_devid == 4'd2 && ev_data == 32'h1111_0002,
                "R8 hold", ev_devid, 2);
            chk(!rsp_valid, "R9 no resp while stalled", rsp_valid, 0);
        end
        ev_ready = 1'b1;
        @(posedge clk);
        #1 ev_ready = 1'b0; wr_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid && rsp_code == 2'(exp_c), "R10 same-cycle accept", rsp_code, exp_c);
        chk(ev_valid == (exp_c == 0), "R10 event after overlap", ev_valid, (exp_c == 0));
        if (exp_c == 0)
            chk(ev_devid == 4'(exp_d), "R10 new devid", ev_devid, exp_d);
        ev_ready = 1'b1;
        @(negedge clk);
        ev_ready = 1'b0;
    endtask

    task automatic xfer_hold(input logic [15:0] a, input logic [31:0] dat);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_strb = 4'hF; wr_data = dat;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        #1 wr_valid = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #5;
        chk(wr_ready && !ev_valid && !rsp_valid, "R1 in reset", {wr_ready, ev_valid, rsp_valid}, 3'b100);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_ready && !ev_valid && !rsp_valid, "R1 after reset", {wr_ready, ev_valid, rsp_valid}, 3'b100);

        // Sweep every ID width, including over-range values (R6), across the window edges
        for (int b = 0; b < 7; b++) begin
            int eff;
            cfg_id_bits = 3'(b);
            eff = (b > 4) ? 4 : b;
            for (int o = -8; o < (4 << eff) + 8; o++)
                xfer(16'(32'h1000 + o), 4'hF, 32'hC0DE_0000 ^ (32'(b) << 12) ^ 32'(o),
                     (b > 4) ? "R6 clamp" : "sweep");
        end

        // Every byte-enable pattern on window, doorbell and outside addresses
        cfg_id_bits = 3'd3;
        for (int s = 0; s < 16; s++) begin
            xfer(16'h100C, 4'(s), 32'hA000_0000 | 32'(s), "strb window");
            xfer(16'h0040, 4'(s), 32'hB000_0000 | 32'(s), "strb doorbell");
            xfer(16'h2000, 4'(s), 32'hD000_0000 | 32'(s), "strb outside");
        end

        // Doorbell inside the window wins (R7)
        cfg_win_base = 16'h0030;
        xfer(16'h0040, 4'hF, 32'h7777_0040, "R7 priority");
        xfer(16'h0044, 4'hF, 32'h7777_0044, "R7 neighbour");
        cfg_win_base = 16'h1000;

        overlap(16'h1010, 0, 4);
        overlap(16'h3000, 2, 0);
        overlap(16'h0040, 0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule